// File: doc/BRIEF.md
# Network Adapter Host Gate Array

This block sits between a host I/O bus and the buffer memory of a network adapter. It answers two 16-byte windows of the host address space. The base window at offset 0 is shared by three sources, and a control register chooses which one is visible: the network controller's own registers (passed straight through), the first half of a 32-byte station-address PROM, or the second half. The gate-array window sits a parameterised distance above the base. It holds the control and status registers, two ring-limit page registers, a 16-bit buffer address and a data port.

The data port is the host end of a programmed-I/O transfer engine built around an 8-byte FIFO. In buffer-to-host mode the engine prefetches bytes from buffer RAM into the FIFO. It raises a ready flag once the FIFO is full, and the host then empties it with four 16-bit accesses or with single byte accesses. In host-to-buffer mode ready means the FIFO is empty. The host pushes up to eight bytes, and the engine drains them into RAM at one byte per clock. Each byte moved in either direction advances the buffer address by one. A small internal RAM model stands in for the buffer memory.

Software reset is a bit in the control register. While that bit is set the register holds a fixed value, and clearing the bit leaves the register reading 0x0A.

Top module: `nic_host_gate`

## Requirements
- R1: After power-on reset the control register (gate-array offset 6) reads 0x0A, the status register reads only the revision, and `xcvr_bnc` follows control bit 1.
- R2: Writing the control register with bit 0 set loads 0x0B. While bit 0 is set, a write changes only bit 0, so a write with bit 0 clear leaves 0x0A. Software reset also ends any running transfer.
- R3: Base-window reads return PROM byte `offset` when control bit 2 is set (regardless of bit 3), PROM byte `16+offset` when only bit 3 is set, and the controller's data when bits 3:2 are both 0.
- R4: When bits 3:2 are 0, a base-window access drives `mac_sel`, `mac_rd`/`mac_wr`, `mac_addr` = offset and `mac_wdata`. In either PROM mapping, base-window writes reach no output.
- R5: Offsets 0 and 1 (ring first/last page) and offsets 9 (address high byte) and 0xA (address low byte) are read/write registers that read back what was written.
- R6: Status (offset 7) bits are {ready, underflow, overflow, terminal count, in progress, revision[2:0]}, from bit 7 down to bit 0. In-progress equals control bit 7 and the revision is a parameter.
- R7: With control bit 6 = 0 and bit 7 = 1, the engine prefetches RAM bytes from the buffer address upward and sets ready when 8 are held. Data-port reads (offset 0xE or 0xF) return them in order. A word read puts the first byte on bits 7:0 and the next on bits 15:8. A byte read returns the byte on bits 7:0 with bits 15:8 at zero.
- R8: With bit 6 = 1 and bit 7 = 1, ready is set while the FIFO is empty. Data-port writes (a word write puts its first byte on bits 7:0) are drained to RAM one byte per clock at consecutive addresses.
- R9: The buffer address advances by one per byte moved and wraps from 0xFFFF to 0x0000. The wrap sets the terminal-count flag.
- R10: A data-port read asking for more bytes than the FIFO holds, or made in host-to-buffer mode, sets underflow, returns 0 and removes nothing. A data-port write with too little room, or made while not in host-to-buffer mode, sets overflow and is dropped.
- R11: A 0-to-1 change of control bit 7 clears underflow, overflow and terminal count. While bit 7 is 0 the FIFO is empty, ready is 0 and nothing moves.
- R12: Gate-array offsets 2 to 5, 8, 0xB, 0xC and 0xD read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| host_addr | input | ADDR_W | Host I/O address relative to the adapter base |
| host_rd | input | 1 | Host read strobe, one access per cycle |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_word | input | 1 | 16-bit access (data port only) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid in the cycle of the access |
| xcvr_bnc | output | 1 | Transceiver select: 1 = coax, 0 = external attachment |
| mac_sel | output | 1 | Base-window access passed to the network controller |
| mac_rd | output | 1 | Pass-through read strobe |
| mac_wr | output | 1 | Pass-through write strobe |
| mac_addr | output | 4 | Pass-through register offset |
| mac_wdata | output | 8 | Pass-through write data |
| mac_rdata | input | 8 | Read data from the network controller |

## Verification
The assertions assume that the host presents at most one access per cycle and never asserts read and write together. They also assume that a word access is made only at the data port and that reset is released synchronously. Under those conditions the FIFO never takes a pop larger than its occupancy and never takes a push beyond its free space. The bench drives every access through a single task that asserts one strobe for exactly one clock cycle, placed between clock edges. It starts a transfer only after the buffer address has been programmed, and it stops the transfer before reprogramming the address. The overflow case is provoked deliberately with back-to-back word writes, which the gate turns into a dropped access, so the FIFO-level properties still hold.

// File: rtl/nga_pkg.sv
`timescale 1ns/1ps
package nga_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned PROM_BYTES = 32;

  // gate-array window offsets
  localparam logic [3:0] OFS_RING_FIRST = 4'h0;
  localparam logic [3:0] OFS_RING_LAST  = 4'h1;
  localparam logic [3:0] OFS_CTRL       = 4'h6;
  localparam logic [3:0] OFS_STAT       = 4'h7;
  localparam logic [3:0] OFS_ADR_HI     = 4'h9;
  localparam logic [3:0] OFS_ADR_LO     = 4'hA;
  localparam logic [3:0] OFS_PORT_A     = 4'hE;
  localparam logic [3:0] OFS_PORT_B     = 4'hF;

  // control bit positions
  localparam int unsigned CB_SRST    = 0;
  localparam int unsigned CB_BNC     = 1;
  localparam int unsigned CB_PROM_LO = 2;
  localparam int unsigned CB_PROM_HI = 3;
  localparam int unsigned CB_DIR     = 6;
  localparam int unsigned CB_GO      = 7;

  localparam logic [7:0] CTRL_RST_VAL = 8'h0A;

  typedef enum logic [1:0] {
    WIN_MAC     = 2'd0,
    WIN_PROM_LO = 2'd1,
    WIN_PROM_HI = 2'd2
  } win_e;
endpackage

// File: rtl/nga_ctrl_reg.sv
`timescale 1ns/1ps
module nga_ctrl_reg
  import nga_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl_q,
  output logic       go_pulse
);
  logic [7:0] ctrl_d;
  logic       in_srst;

  assign in_srst = ctrl_q[CB_SRST];

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) begin
      if (in_srst || wdata[CB_SRST]) begin
        ctrl_d = CTRL_RST_VAL | {7'b0, wdata[CB_SRST]};
      end else begin
        ctrl_d = wdata;
      end
    end
  end

  assign go_pulse = we && !in_srst && !wdata[CB_SRST] &&
                    wdata[CB_GO] && !ctrl_q[CB_GO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST_VAL;
    else        ctrl_q <= ctrl_d;
  end

  // R2
  srst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_srst && we && !wdata[CB_SRST]) |=> (ctrl_q == CTRL_RST_VAL));
endmodule

// File: rtl/nga_fifo.sv
`timescale 1ns/1ps
module nga_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic [1:0]     push_n,
  input  logic [2*W-1:0] push_data,
  input  logic [1:0]     pop_n,
  output logic [2*W-1:0] head,
  output logic [CW-1:0]  count
);
  localparam logic [PW-1:0] P_ONE = PW'(1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d, rd_nx, wr_nx;
  logic [CW-1:0] cnt_d;

  assign rd_nx = rd_q + P_ONE;
  assign wr_nx = wr_q + P_ONE;

  always_comb begin
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      rd_d  = rd_q + PW'(pop_n);
      wr_d  = wr_q + PW'(push_n);
      cnt_d = count + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      count <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && push_n != 2'd0) mem[wr_q]  <= push_data[W-1:0];
    if (!flush && push_n == 2'd2) mem[wr_nx] <= push_data[2*W-1:W];
  end

  assign head = {mem[rd_nx], mem[rd_q]};

  // R10
  no_underpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (int'(pop_n) <= int'(count)));
  // R10
  no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (int'(push_n) + int'(count) <= int'(DEPTH) + int'(pop_n)));
endmodule

// File: rtl/nga_buf_ram.sv
`timescale 1ns/1ps
module nga_buf_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned W  = 8,
  localparam int unsigned WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/nga_xfer.sv
`timescale 1ns/1ps
module nga_xfer #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned RAM_AW = 10,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              dir_wr,
  input  logic              go_pulse,
  input  logic              srst,
  input  logic              adr_hi_we,
  input  logic              adr_lo_we,
  input  logic [7:0]        reg_wdata,
  input  logic              port_rd,
  input  logic              port_wr,
  input  logic [1:0]        port_n,
  input  logic [15:0]       port_wdata,
  output logic [15:0]       port_rdata,
  output logic [15:0]       addr_q,
  output logic              ready,
  output logic              ufl_q,
  output logic              ovf_q,
  output logic              tc_q,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt;
  logic [15:0]   head;
  logic [1:0]    push_n, pop_n;
  logic [15:0]   push_data;
  logic          rd_mode, wr_mode, prefetch, drain, moved;
  logic          pop_ok, push_ok, addr_wr;
  logic [15:0]   addr_d;
  logic          ufl_d, ovf_d, tc_d, flags_clr;

  assign rd_mode  = go && !dir_wr;
  assign wr_mode  = go && dir_wr;
  assign prefetch = rd_mode && (cnt < FULL);
  assign drain    = wr_mode && (cnt != '0);
  assign moved    = prefetch || drain;
  assign addr_wr  = adr_hi_we || adr_lo_we;

  assign pop_ok  = port_rd && rd_mode && (cnt >= CW'(port_n));
  assign push_ok = port_wr && wr_mode && ((FULL - cnt) >= CW'(port_n));

  always_comb begin
    push_n    = 2'd0;
    push_data = port_wdata;
    pop_n     = 2'd0;
    if (prefetch) begin
      push_n    = 2'd1;
      push_data = {8'h00, ram_rdata};
    end else if (push_ok) begin
      push_n    = port_n;
    end
    if (drain)       pop_n = 2'd1;
    else if (pop_ok) pop_n = port_n;
  end

  nga_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!go),
    .push_n    (push_n),
    .push_data (push_data),
    .pop_n     (pop_n),
    .head      (head),
    .count     (cnt)
  );

  always_comb begin
    port_rdata = 16'h0000;
    if (pop_ok) begin
      port_rdata = (port_n == 2'd2) ? head : {8'h00, head[7:0]};
    end
  end

  assign ready = (rd_mode && cnt == FULL) || (wr_mode && cnt == '0);

  assign ram_we    = drain;
  assign ram_addr  = addr_q[RAM_AW-1:0];
  assign ram_wdata = head[7:0];

  always_comb begin
    addr_d = addr_q;
    if (addr_wr) begin
      if (adr_hi_we) addr_d[15:8] = reg_wdata;
      if (adr_lo_we) addr_d[7:0]  = reg_wdata;
    end else if (moved) begin
      addr_d = addr_q + 16'd1;
    end
  end

  assign flags_clr = go_pulse || srst;

  always_comb begin
    ufl_d = ufl_q;
    ovf_d = ovf_q;
    tc_d  = tc_q;
    if (flags_clr) begin
      ufl_d = 1'b0;
      ovf_d = 1'b0;
      tc_d  = 1'b0;
    end else begin
      if (port_rd && !pop_ok)  ufl_d = 1'b1;
      if (port_wr && !push_ok) ovf_d = 1'b1;
      if (moved && !addr_wr && addr_q == 16'hFFFF) tc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ufl_q  <= 1'b0;
      ovf_q  <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      ufl_q  <= ufl_d;
      ovf_q  <= ovf_d;
      tc_q   <= tc_d;
    end
  end

  // R11
  go_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |=> (!ufl_q && !ovf_q && !tc_q));
  // R11
  stop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (cnt == '0));
  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && !addr_wr) |=> (addr_q == $past(addr_q) + 16'd1));
endmodule

// File: rtl/nic_host_gate.sv
`timescale 1ns/1ps
module nic_host_gate
  import nga_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter logic [ADDR_W-1:0] GA_OFFSET = 11'h400,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned RAM_AW    = 10,
  parameter logic [2:0]  REV       = 3'd2,
  parameter logic [PROM_BYTES*8-1:0] PROM_INIT =
    256'h1F1E1D1C1B1A191817161514131211100F0E0D0C0B0A09080706050403020100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_word,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              xcvr_bnc,
  output logic              mac_sel,
  output logic              mac_rd,
  output logic              mac_wr,
  output logic [3:0]        mac_addr,
  output logic [7:0]        mac_wdata,
  input  logic [7:0]        mac_rdata
);
  localparam int unsigned PAGE_W = ADDR_W - 4;

  logic [3:0]  ofs;
  logic        hit_base, hit_ga, ga_wr, ga_rd;
  logic [7:0]  ctrl_q, stat;
  logic        go_pulse;
  win_e        win;
  logic [7:0]  ring_first_q, ring_first_d, ring_last_q, ring_last_d;
  logic        port_hit, port_rd, port_wr;
  logic [1:0]  port_n;
  logic [15:0] port_rdata, addr_q;
  logic        ready, ufl, ovf, tc;
  logic        ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;

  assign ofs      = host_addr[3:0];
  assign hit_base = host_addr[ADDR_W-1:4] == '0;
  assign hit_ga   = host_addr[ADDR_W-1:4] == GA_OFFSET[ADDR_W-1:4];
  assign ga_wr    = hit_ga && host_wr;
  assign ga_rd    = hit_ga && host_rd;

  nga_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ga_wr && ofs == OFS_CTRL),
    .wdata    (host_wdata[7:0]),
    .ctrl_q   (ctrl_q),
    .go_pulse (go_pulse)
  );

  assign xcvr_bnc = ctrl_q[CB_BNC];

  always_comb begin
    if (ctrl_q[CB_PROM_LO])      win = WIN_PROM_LO;
    else if (ctrl_q[CB_PROM_HI]) win = WIN_PROM_HI;
    else                         win = WIN_MAC;
  end

  // base window pass-through
  assign mac_sel   = hit_base && (win == WIN_MAC) && (host_rd || host_wr);
  assign mac_rd    = mac_sel && host_rd;
  assign mac_wr    = mac_sel && host_wr;
  assign mac_addr  = ofs;
  assign mac_wdata = host_wdata[7:0];

  // ring page registers
  always_comb begin
    ring_first_d = ring_first_q;
    ring_last_d  = ring_last_q;
    if (ga_wr && ofs == OFS_RING_FIRST) ring_first_d = host_wdata[7:0];
    if (ga_wr && ofs == OFS_RING_LAST)  ring_last_d  = host_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_first_q <= '0;
      ring_last_q  <= '0;
    end else begin
      ring_first_q <= ring_first_d;
      ring_last_q  <= ring_last_d;
    end
  end

  // data port
  assign port_hit = hit_ga && (ofs == OFS_PORT_A || ofs == OFS_PORT_B);
  assign port_rd  = port_hit && host_rd;
  assign port_wr  = port_hit && host_wr;
  assign port_n   = host_word ? 2'd2 : 2'd1;

  nga_xfer #(.DEPTH(FIFO_DEPTH), .RAM_AW(RAM_AW)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (ctrl_q[CB_GO]),
    .dir_wr     (ctrl_q[CB_DIR]),
    .go_pulse   (go_pulse),
    .srst       (ctrl_q[CB_SRST]),
    .adr_hi_we  (ga_wr && ofs == OFS_ADR_HI),
    .adr_lo_we  (ga_wr && ofs == OFS_ADR_LO),
    .reg_wdata  (host_wdata[7:0]),
    .port_rd    (port_rd),
    .port_wr    (port_wr),
    .port_n     (port_n),
    .port_wdata (host_wdata),
    .port_rdata (port_rdata),
    .addr_q     (addr_q),
    .ready      (ready),
    .ufl_q      (ufl),
    .ovf_q      (ovf),
    .tc_q       (tc),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata)
  );

  nga_buf_ram #(.AW(RAM_AW), .W(8)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  assign stat = {ready, ufl, ovf, tc, ctrl_q[CB_GO], REV};

  function automatic logic [7:0] prom_byte(input logic [4:0] idx);
    return PROM_INIT[{idx, 3'b000} +: 8];
  endfunction

  always_comb begin
    host_rdata = 16'h0000;
    if (hit_base) begin
      unique case (win)
        WIN_PROM_LO: host_rdata = {8'h00, prom_byte({1'b0, ofs})};
        WIN_PROM_HI: host_rdata = {8'h00, prom_byte({1'b1, ofs})};
        default:     host_rdata = {8'h00, mac_rdata};
      endcase
    end else if (hit_ga) begin
      unique case (ofs)
        OFS_RING_FIRST: host_rdata = {8'h00, ring_first_q};
        OFS_RING_LAST:  host_rdata = {8'h00, ring_last_q};
        OFS_CTRL:       host_rdata = {8'h00, ctrl_q};
        OFS_STAT:       host_rdata = {8'h00, stat};
        OFS_ADR_HI:     host_rdata = {8'h00, addr_q[15:8]};
        OFS_ADR_LO:     host_rdata = {8'h00, addr_q[7:0]};
        OFS_PORT_A,
        OFS_PORT_B:     host_rdata = port_rdata;
        default:        host_rdata = 16'h0000;
      endcase
    end
  end

  // R4
  prom_blocks_mac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_base && host_wr && (ctrl_q[CB_PROM_LO] || ctrl_q[CB_PROM_HI])) |-> !mac_wr);
  // R6
  busy_tracks_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |=> stat[3]);

  logic unused_page;
  assign unused_page = ^PAGE_W;
endmodule

// File: tb/test_nic_host_gate.sv
`timescale 1ns/1ps
module test_nic_host_gate;
  localparam logic [10:0] GA = 11'h400;
  localparam logic [2:0]  TB_REV = 3'd5;

  function automatic logic [255:0] mk_prom();
    logic [255:0] p;
    for (int i = 0; i < 32; i++) p[i*8 +: 8] = 8'h30 + 8'(i);
    return p;
  endfunction
  localparam logic [255:0] TB_PROM = mk_prom();

  logic        clk, rst_n;
  logic [10:0] host_addr;
  logic        host_rd, host_wr, host_word;
  logic [15:0] host_wdata, host_rdata;
  logic        xcvr_bnc, mac_sel, mac_rd, mac_wr;
  logic [3:0]  mac_addr;
  logic [7:0]  mac_wdata, mac_rdata;

  int n_chk, n_fail;
  logic [15:0] rd_v;
  logic        seen_sel, seen_rd, seen_wr;
  logic [3:0]  seen_addr;
  logic [7:0]  seen_wd;

  nic_host_gate #(.REV(TB_REV), .PROM_INIT(TB_PROM)) i_nic_host_gate (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_word(host_word), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .xcvr_bnc(xcvr_bnc), .mac_sel(mac_sel),
    .mac_rd(mac_rd), .mac_wr(mac_wr), .mac_addr(mac_addr),
    .mac_wdata(mac_wdata), .mac_rdata(mac_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [10:0] a, input bit rd, input bit wr,
                     input bit word, input logic [15:0] wd);
    @(negedge clk);
    host_addr = a; host_rd = rd; host_wr = wr; host_word = word; host_wdata = wd;
    #2;
    rd_v = host_rdata;
    seen_sel = mac_sel; seen_rd = mac_rd; seen_wr = mac_wr;
    seen_addr = mac_addr; seen_wd = mac_wdata;
    @(posedge clk);
    #1;
    host_rd = 1'b0; host_wr = 1'b0; host_word = 1'b0;
  endtask

  task automatic wr8(input logic [10:0] a, input logic [7:0] d);
    acc(a, 1'b0, 1'b1, 1'b0, {8'h00, d});
  endtask
  task automatic rd8(input logic [10:0] a);
    acc(a, 1'b1, 1'b0, 1'b0, 16'h0000);
  endtask
  task automatic set_addr(input logic [15:0] a);
    wr8(GA + 11'h9, a[15:8]);
    wr8(GA + 11'hA, a[7:0]);
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask
  task automatic wait_ready(input string req);
    for (int i = 0; i < 30; i++) begin
      rd8(GA + 11'h7);
      if (rd_v[7]) break;
    end
    chk(req, {15'h0, rd_v[7]}, 16'h0001);
  endtask

  task automatic t_reset;
    rd8(GA + 11'h6);  chk("R1 ctrl after reset", rd_v, 16'h000A);
    chk("R1 bnc after reset", {15'h0, xcvr_bnc}, 16'h0001);
    rd8(11'h003);     chk("R1 base shows PROM byte 19", rd_v, 16'h0043);
    rd8(GA + 11'h7);  chk("R6 status after reset", rd_v, {13'h0, TB_REV});
  endtask

  task automatic t_window;
    wr8(GA + 11'h6, 8'h04);
    rd8(11'h005);     chk("R3 low PROM map", rd_v, 16'h0035);
    chk("R1 bnc cleared", {15'h0, xcvr_bnc}, 16'h0000);
    wr8(GA + 11'h6, 8'h0C);
    rd8(11'h005);     chk("R3 bit2 wins over bit3", rd_v, 16'h0035);
    wr8(GA + 11'h6, 8'h08);
    rd8(11'h005);     chk("R3 high PROM map", rd_v, 16'h0045);
    wr8(11'h007, 8'h77);
    chk("R4 PROM-mapped write blocked", {14'h0, seen_sel, seen_wr}, 16'h0000);
    wr8(GA + 11'h6, 8'h00);
    rd8(11'h003);     chk("R3 controller pass-through data", rd_v, 16'h005A);
    chk("R4 pass-through read strobes", {12'h0, seen_addr}, 16'h0003);
    chk("R4 pass-through read select", {14'h0, seen_sel, seen_rd}, 16'h0003);
    wr8(11'h007, 8'h77);
    chk("R4 pass-through write", {6'h0, seen_sel, seen_wr, seen_wd}, 16'h0377);
  endtask

  task automatic t_soft_reset;
    wr8(GA + 11'h6, 8'hC0);
    wr8(GA + 11'h6, 8'h01);
    rd8(GA + 11'h6);  chk("R2 ctrl in soft reset", rd_v, 16'h000B);
    rd8(GA + 11'h7);  chk("R2 soft reset stops transfer", {15'h0, rd_v[3]}, 16'h0000);
    wr8(GA + 11'h6, 8'hF1);
    rd8(GA + 11'h6);  chk("R2 writes held during reset", rd_v, 16'h000B);
    wr8(GA + 11'h6, 8'h00);
    rd8(GA + 11'h6);  chk("R2 release leaves 0x0A", rd_v, 16'h000A);
  endtask

  task automatic t_regs;
    wr8(GA + 11'h0, 8'h26);
    wr8(GA + 11'h1, 8'h40);
    rd8(GA + 11'h0);  chk("R5 ring first", rd_v, 16'h0026);
    rd8(GA + 11'h1);  chk("R5 ring last", rd_v, 16'h0040);
    set_addr(16'hABCD);
    rd8(GA + 11'h9);  chk("R5 address high", rd_v, 16'h00AB);
    rd8(GA + 11'hA);  chk("R5 address low", rd_v, 16'h00CD);
    wr8(GA + 11'hC, 8'hFF);
    rd8(GA + 11'hC);  chk("R12 unused offset C", rd_v, 16'h0000);
    rd8(GA + 11'h3);  chk("R12 unused offset 3", rd_v, 16'h0000);
  endtask

  task automatic t_move;
    wr8(GA + 11'h6, 8'h00);
    set_addr(16'h0100);
    wr8(GA + 11'h6, 8'hC0);
    rd8(GA + 11'h7);  chk("R8 ready when empty", rd_v, {8'h0, 8'h88 | {5'h0, TB_REV}});
    for (int i = 0; i < 4; i++)
      acc(GA + 11'hE, 1'b0, 1'b1, 1'b1, {8'hA1 + 8'(2*i), 8'hA0 + 8'(2*i)});
    idle(10);
    rd8(GA + 11'h9);  chk("R9 address high after drain", rd_v, 16'h0001);
    rd8(GA + 11'hA);  chk("R9 address low after drain", rd_v, 16'h0008);
    wr8(GA + 11'h6, 8'h00);
    rd8(GA + 11'h7);  chk("R11 stop clears ready and busy", rd_v, {13'h0, TB_REV});
    set_addr(16'h0100);
    wr8(GA + 11'h6, 8'h80);
    wait_ready("R7 ready after prefetch");
    for (int i = 0; i < 4; i++) begin
      acc(GA + 11'hE, 1'b1, 1'b0, 1'b1, 16'h0000);
      chk("R7 word read data", rd_v, {8'hA1 + 8'(2*i), 8'hA0 + 8'(2*i)});
    end
    wr8(GA + 11'h6, 8'h00);
    set_addr(16'h0105);
    wr8(GA + 11'h6, 8'h80);
    wait_ready("R7 ready for byte read");
    rd8(GA + 11'hF);  chk("R7 byte read data", rd_v, 16'h00A5);
    rd8(GA + 11'hE);  chk("R7 byte read next", rd_v, 16'h00A6);
    rd8(GA + 11'h7);  chk("R8 underflow stays clear", {15'h0, rd_v[6]}, 16'h0000);
  endtask

  task automatic t_flags;
    wr8(GA + 11'h6, 8'h00);
    wr8(GA + 11'h6, 8'h80);
    rd8(GA + 11'hE);  chk("R10 empty read returns 0", rd_v, 16'h0000);
    rd8(GA + 11'h7);  chk("R10 underflow set", {15'h0, rd_v[6]}, 16'h0001);
    wr8(GA + 11'h6, 8'h00);
    wr8(GA + 11'h6, 8'h80);
    rd8(GA + 11'h7);  chk("R11 restart clears underflow", {15'h0, rd_v[6]}, 16'h0000);
    wr8(GA + 11'h6, 8'h00);
    set_addr(16'h0200);
    wr8(GA + 11'h6, 8'hC0);
    for (int i = 0; i < 8; i++)
      acc(GA + 11'hE, 1'b0, 1'b1, 1'b1, 16'h5555);
    rd8(GA + 11'h7);  chk("R10 overflow set", {15'h0, rd_v[5]}, 16'h0001);
    wr8(GA + 11'h6, 8'h00);
    wr8(GA + 11'h6, 8'hC0);
    rd8(GA + 11'h7);  chk("R11 restart clears overflow", {15'h0, rd_v[5]}, 16'h0000);
    wr8(GA + 11'h6, 8'h00);
  endtask

  task automatic t_wrap;
    set_addr(16'hFFFC);
    wr8(GA + 11'h6, 8'hC0);
    for (int i = 0; i < 4; i++)
      acc(GA + 11'hE, 1'b0, 1'b1, 1'b1, {8'hC1 + 8'(2*i), 8'hC0 + 8'(2*i)});
    idle(12);
    rd8(GA + 11'h7);  chk("R9 terminal count on wrap", {15'h0, rd_v[4]}, 16'h0001);
    rd8(GA + 11'h9);  chk("R9 wrapped address high", rd_v, 16'h0000);
    rd8(GA + 11'hA);  chk("R9 wrapped address low", rd_v, 16'h0004);
    wr8(GA + 11'h6, 8'h00);
    set_addr(16'hFFFC);
    wr8(GA + 11'h6, 8'h80);
    wait_ready("R9 ready across wrap");
    for (int i = 0; i < 4; i++) begin
      acc(GA + 11'hF, 1'b1, 1'b0, 1'b1, 16'h0000);
      chk("R9 data across wrap", rd_v, {8'hC1 + 8'(2*i), 8'hC0 + 8'(2*i)});
    end
    wr8(GA + 11'h6, 8'h00);
    set_addr(16'h0000);
    wr8(GA + 11'h6, 8'h80);
    rd8(GA + 11'h7);  chk("R11 restart clears terminal count", {15'h0, rd_v[4]}, 16'h0000);
    wait_ready("R11 ready before stop");
    wr8(GA + 11'h6, 8'h00);
    rd8(GA + 11'hE);  chk("R11 stop empties FIFO", rd_v, 16'h0000);
    rd8(GA + 11'h7);  chk("R11 stop then read underflows", {14'h0, rd_v[7:6]}, 16'h0001);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    host_addr = '0; host_rd = 0; host_wr = 0; host_word = 0; host_wdata = '0;
    mac_rdata = 8'h5A;
    rst_n = 1'b0;
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_window();
    t_soft_reset();
    t_regs();
    t_move();
    t_flags();
    t_wrap();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule